// File: doc/BRIEF.md
# Musical note PWM generator

This block drives a piezo buzzer with a pulse-width-modulated tone whose pitch walks through a fixed melody. A wrapping up-counter sets the tone period and a compare threshold sets when the output goes high inside each period. The share of each period that the output is high sets the loudness. A slow reference clock feeds a two-stage prescaler. This produces a one-second tick. On each tick the melody moves to its next note and two indicator LEDs swap states.

Two active-low push buttons change the compare threshold while a note plays. One makes the tone quieter and the other makes it louder. Each button passes through a two-flop synchroniser and a hold-time debounce filter before it acts. New period and threshold values wait in holding registers. They reach the counter only when it wraps, so every PWM cycle on the pin is complete.

Top module: `tone_melody_pwm`

## Requirements
- R1: The tone counter counts 0, 1, … up to the active period value P and then restarts at 0, so one PWM cycle lasts P+1 system clocks.
- R2: The buzzer output is registered and is 0 during reset. It goes high the clock after the counter equals the active threshold T and goes low the clock after the counter equals P. Each cycle is therefore P−T clocks high and T+1 clocks low.
- R3: The melody has nine notes. Their base period values in playing order (index 0 to 8) are 15895, 15258, 13620, 12077, 11405, 10159, 9106, 7963 and 7629. The value used is the base value shifted right by the parameter PITCH_SHIFT, which defaults to 0.
- R4: After reset, note 0 plays with T = P/2 (integer division), LED1 is on (1) and LED2 is off (0).
- R5: A tick occurs every REF_DIV_A × REF_DIV_B reference-clock cycles. On each tick both LED outputs invert, so they are always opposite.
- R6: On each tick the melody index advances by one, wrapping from 8 to 0. The new note's period is loaded with its threshold reset to half its period.
- R7: Let S = P/16 (integer division). A debounced press of the quiet button raises T by S, clamped at P−S. A debounced press of the loud button lowers T by S, clamped at S. If both presses arrive in the same clock, the quiet press wins.
- R8: Period and threshold changes from a tick or a press are held back and reach the counter only at the clock where the counter wraps from P to 0.
- R9: A button level must stay steady for DEBOUNCE_CYCLES system clocks after synchronisation before it is accepted. A press is counted once, on the accepted high-to-low change. A low pulse shorter than the hold time has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sys | input | 1 | System clock that runs the tone counter |
| clk_ref | input | 1 | Slow reference clock for the one-second prescaler |
| rst_n | input | 1 | Synchronous active-low reset, held for at least two reference-clock cycles |
| btn_quiet_n | input | 1 | Active-low button that lowers the loudness |
| btn_loud_n | input | 1 | Active-low button that raises the loudness |
| buzzer_o | output | 1 | PWM tone output |
| led1_o | output | 1 | First indicator LED, on after reset |
| led2_o | output | 1 | Second indicator LED, always opposite to led1_o |

## Verification
The hardest case to reach from the pins is a threshold change that arrives in the middle of a PWM cycle. In that case the cycle on the pin must still finish with its old compare point, and the new value must apply only after the wrap. To reach it, the stimulus waits for a falling edge of the buzzer, which marks a counter wrap, and then presses the loud button at once. The debounced press then lands well before the old compare point. The rise-to-rise cycle that spans the change must show the old high time followed by the new low time, and that total differs from the total that any immediate update would produce. Clamping is reached by pressing one button more times than there are steps between half duty and the limit, all within a single note.

// File: rtl/tone_pkg.sv
// Shared widths and the melody table for the note PWM generator.
// Assumes period values fit in PERIOD_W bits after the pitch shift.
package tone_pkg;

    localparam int PERIOD_W   = 16;
    localparam int NOTE_COUNT = 9;
    localparam int NOTE_IDX_W = $clog2(NOTE_COUNT);

    // Returns the tone period for a melody index, scaled down by shift.
    function automatic logic [PERIOD_W-1:0] note_period(
        input logic [NOTE_IDX_W-1:0] idx,
        input int                    shift
    );
        logic [PERIOD_W-1:0] base;
        case (idx)
            4'd0:    base = 16'd15895;
            4'd1:    base = 16'd15258;
            4'd2:    base = 16'd13620;
            4'd3:    base = 16'd12077;
            4'd4:    base = 16'd11405;
            4'd5:    base = 16'd10159;
            4'd6:    base = 16'd9106;
            4'd7:    base = 16'd7963;
            4'd8:    base = 16'd7629;
            default: base = 16'd15895;
        endcase
        return base >> shift;
    endfunction

endpackage

// File: rtl/tone_tick_gen.sv
// Two-stage prescaler in the reference clock domain. It flips a toggle
// every DIV_A*DIV_B reference cycles, and the toggle is brought into the
// system domain as a one-clock tick pulse.
// Assumes clk_ref is at least four times slower than clk_sys, DIV_A and
// DIV_B are at least 2, and rst_n is held for two or more clk_ref cycles.
module tone_tick_gen #(
    parameter int unsigned DIV_A = 256,
    parameter int unsigned DIV_B = 128
) (
    input  logic clk_ref,
    input  logic clk_sys,
    input  logic rst_n,
    output logic tick_o
);

    localparam int A_W = $clog2(DIV_A);
    localparam int B_W = $clog2(DIV_B);

    logic [A_W-1:0] stage_a_q;
    logic [B_W-1:0] stage_b_q;
    logic           toggle_q;
    logic [2:0]     sync_q;

    // Cascaded divide in the reference domain; the toggle flips when both stages wrap.
    always_ff @(posedge clk_ref) begin
        if (!rst_n) begin
            stage_a_q <= '0;
            stage_b_q <= '0;
            toggle_q  <= 1'b0;
        end else if (stage_a_q == A_W'(DIV_A - 1)) begin
            stage_a_q <= '0;
            if (stage_b_q == B_W'(DIV_B - 1)) begin
                stage_b_q <= '0;
                toggle_q  <= ~toggle_q;
            end else begin
                stage_b_q <= stage_b_q + 1'b1;
            end
        end else begin
            stage_a_q <= stage_a_q + 1'b1;
        end
    end

    // Carry the toggle into the system domain through a flop chain.
    always_ff @(posedge clk_sys) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[1:0], toggle_q};
        end
    end

    assign tick_o = sync_q[2] ^ sync_q[1];

    AST_TICK_SINGLE: assert property (@(posedge clk_sys) disable iff (!rst_n)
        tick_o |=> !tick_o); // R5

endmodule

// File: rtl/tone_key_filter.sv
// Button conditioner: two-flop synchroniser, then a filter that accepts a
// new level only after it has held for HOLD_CYCLES clocks. Emits a single
// pulse when the accepted level goes from released (1) to pressed (0).
// Assumes an active-low button that idles high; HOLD_CYCLES is at least 2.
module tone_key_filter #(
    parameter int unsigned HOLD_CYCLES = 79954
) (
    input  logic clk,
    input  logic rst_n,
    input  logic key_n_i,
    output logic press_o
);

    localparam int CNT_W = $clog2(HOLD_CYCLES + 1);

    logic [1:0]       sync_q;
    logic             level_q;
    logic [CNT_W-1:0] hold_q;
    logic             press_q;

    // Bring the raw button level into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= 2'b11;
        end else begin
            sync_q <= {sync_q[0], key_n_i};
        end
    end

    // Accept a changed level once it has held long enough; pulse on the press edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= 1'b1;
            hold_q  <= '0;
            press_q <= 1'b0;
        end else if (sync_q[1] == level_q) begin
            hold_q  <= '0;
            press_q <= 1'b0;
        end else if (hold_q == CNT_W'(HOLD_CYCLES - 1)) begin
            level_q <= sync_q[1];
            hold_q  <= '0;
            press_q <= ~sync_q[1];
        end else begin
            hold_q  <= hold_q + 1'b1;
            press_q <= 1'b0;
        end
    end

    assign press_o = press_q;

    AST_PRESS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        press_o |=> !press_o); // R9

endmodule

// File: rtl/tone_pwm_core.sv
// Wrapping tone counter with a set/reset compare output. The output goes
// high after the count meets the threshold and low after it meets the
// period. Period and threshold inputs are sampled only on a wrap.
// Assumes thresh_i < period_i whenever the inputs are sampled.
module tone_pwm_core #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] period_i,
    input  logic [W-1:0] thresh_i,
    output logic         pwm_o
);

    logic [W-1:0] cnt_q;
    logic [W-1:0] per_q;
    logic [W-1:0] thr_q;
    logic         out_q;
    logic         wrap;

    assign wrap = (cnt_q == per_q);

    // Count, reload the held settings on a wrap, and drive the set/reset output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            per_q <= period_i;
            thr_q <= thresh_i;
            out_q <= 1'b0;
        end else if (wrap) begin
            cnt_q <= '0;
            per_q <= period_i;
            thr_q <= thresh_i;
            out_q <= 1'b0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == thr_q) begin
                out_q <= 1'b1;
            end
        end
    end

    assign pwm_o = out_q;

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= per_q); // R1
    AST_LOW_AFTER_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> !pwm_o); // R2
    AST_HOLD_MIDCYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> ($stable(per_q) && $stable(thr_q))); // R8

endmodule

// File: rtl/tone_melody_pwm.sv
// Top of the note PWM generator. It steps a melody index on every
// one-second tick, keeps the pending period and threshold, adjusts the
// threshold from the two filtered buttons, and drives the antiphase LEDs.
// Assumes the PWM core picks up the pending values only on its wrap.
module tone_melody_pwm #(
    parameter int          PITCH_SHIFT     = 0,
    parameter int unsigned REF_DIV_A       = 256,
    parameter int unsigned REF_DIV_B       = 128,
    parameter int unsigned DEBOUNCE_CYCLES = 79954,
    parameter int          DUTY_SHIFT      = 4
) (
    input  logic clk_sys,
    input  logic clk_ref,
    input  logic rst_n,
    input  logic btn_quiet_n,
    input  logic btn_loud_n,
    output logic buzzer_o,
    output logic led1_o,
    output logic led2_o
);

    import tone_pkg::*;

    localparam logic [NOTE_IDX_W-1:0] LAST_IDX = NOTE_IDX_W'(NOTE_COUNT - 1);

    logic                  tick;
    logic [1:0]            key_n;
    logic [1:0]            press;
    logic [NOTE_IDX_W-1:0] idx_q;
    logic [NOTE_IDX_W-1:0] idx_next;
    logic [PERIOD_W-1:0]   pend_per_q;
    logic [PERIOD_W-1:0]   pend_thr_q;
    logic [PERIOD_W-1:0]   next_per;
    logic [PERIOD_W-1:0]   step;
    logic [PERIOD_W-1:0]   thr_ceiling;
    logic [PERIOD_W:0]     thr_sum;
    logic [PERIOD_W:0]     thr_floor2;
    logic [PERIOD_W-1:0]   thr_quieter;
    logic [PERIOD_W-1:0]   thr_louder;
    logic                  led_q;

    tone_tick_gen #(
        .DIV_A (REF_DIV_A),
        .DIV_B (REF_DIV_B)
    ) u_tick (
        .clk_ref (clk_ref),
        .clk_sys (clk_sys),
        .rst_n   (rst_n),
        .tick_o  (tick)
    );

    // Index 0 is the quiet button, index 1 the loud button.
    assign key_n = {btn_loud_n, btn_quiet_n};

    for (genvar k = 0; k < 2; k++) begin : g_key
        tone_key_filter #(
            .HOLD_CYCLES (DEBOUNCE_CYCLES)
        ) u_key (
            .clk     (clk_sys),
            .rst_n   (rst_n),
            .key_n_i (key_n[k]),
            .press_o (press[k])
        );
    end

    // Next melody index, wrapping after the last note.
    assign idx_next = (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
    assign next_per = note_period(idx_next, PITCH_SHIFT);

    // Duty step and the clamped threshold for each button.
    always_comb begin
        step        = pend_per_q >> DUTY_SHIFT;
        thr_ceiling = pend_per_q - step;
        thr_sum     = {1'b0, pend_thr_q} + {1'b0, step};
        thr_floor2  = {1'b0, step} + {1'b0, step};
        thr_quieter = (thr_sum > {1'b0, thr_ceiling}) ? thr_ceiling : thr_sum[PERIOD_W-1:0];
        thr_louder  = ({1'b0, pend_thr_q} < thr_floor2) ? step : (pend_thr_q - step);
    end

    // Melody stepping, pending settings and LED state.
    always_ff @(posedge clk_sys) begin
        if (!rst_n) begin
            idx_q      <= '0;
            pend_per_q <= note_period('0, PITCH_SHIFT);
            pend_thr_q <= note_period('0, PITCH_SHIFT) >> 1;
            led_q      <= 1'b1;
        end else if (tick) begin
            idx_q      <= idx_next;
            pend_per_q <= next_per;
            pend_thr_q <= next_per >> 1;
            led_q      <= ~led_q;
        end else if (press[0]) begin
            pend_thr_q <= thr_quieter;
        end else if (press[1]) begin
            pend_thr_q <= thr_louder;
        end
    end

    tone_pwm_core #(
        .W (PERIOD_W)
    ) u_pwm (
        .clk      (clk_sys),
        .rst_n    (rst_n),
        .period_i (pend_per_q),
        .thresh_i (pend_thr_q),
        .pwm_o    (buzzer_o)
    );

    assign led1_o = led_q;
    assign led2_o = ~led_q;

    AST_LED_FLIP: assert property (@(posedge clk_sys) disable iff (!rst_n)
        tick |=> (led_q != $past(led_q))); // R5
    AST_IDX_RANGE: assert property (@(posedge clk_sys) disable iff (!rst_n)
        idx_q <= LAST_IDX); // R6
    AST_THR_CLAMP: assert property (@(posedge clk_sys) disable iff (!rst_n)
        (pend_thr_q >= step) && (pend_thr_q <= pend_per_q - step)); // R7

endmodule

// File: tb/tb_tone_melody_pwm.sv
`timescale 1ns/1ps
module tb_tone_melody_pwm;

    localparam int SHIFT  = 6;
    localparam int DIV_A  = 8;
    localparam int DIV_B  = 32;
    localparam int HOLD   = 8;
    localparam int SETTLE = 300;

    logic clk_sys = 1'b0;
    logic clk_ref = 1'b0;
    logic rst_n = 1'b0;
    logic btn_quiet_n = 1'b1;
    logic btn_loud_n = 1'b1;
    logic buzzer, led1, led2;

    always #2.5 clk_sys = ~clk_sys;
    always #20  clk_ref = ~clk_ref;

    tone_melody_pwm #(
        .PITCH_SHIFT     (SHIFT),
        .REF_DIV_A       (DIV_A),
        .REF_DIV_B       (DIV_B),
        .DEBOUNCE_CYCLES (HOLD),
        .DUTY_SHIFT      (4)
    ) dut (
        .clk_sys     (clk_sys),
        .clk_ref     (clk_ref),
        .rst_n       (rst_n),
        .btn_quiet_n (btn_quiet_n),
        .btn_loud_n  (btn_loud_n),
        .buzzer_o    (buzzer),
        .led1_o      (led1),
        .led2_o      (led2)
    );

    typedef struct {
        int    high;
        int    total;
        string tag;
    } exp_t;

    exp_t sb_q[$];
    int   checks = 0;
    int   errors = 0;

    // Melody periods from the requirement table, scaled by the pitch shift.
    function automatic int per_of(input int idx);
        int b;
        case (idx)
            0: b = 15895; 1: b = 15258; 2: b = 13620;
            3: b = 12077; 4: b = 11405; 5: b = 10159;
            6: b = 9106;  7: b = 7963;  default: b = 7629;
        endcase
        return b >> SHIFT;
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk_sys);
    endtask

    task automatic push_exp(input int h, input int t, input string tag);
        exp_t e;
        e.high = h; e.total = t; e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic drain();
        wait (sb_q.size() == 0);
        @(negedge clk_sys);
    endtask

    // which: 0 = quiet button, 1 = loud button; low_len clocks held down.
    task automatic press(input int which, input int low_len);
        @(negedge clk_sys);
        if (which == 0) btn_quiet_n = 1'b0; else btn_loud_n = 1'b0;
        idle(low_len);
        btn_quiet_n = 1'b1;
        btn_loud_n  = 1'b1;
        idle(20);
    endtask

    task automatic wait_tick();
        logic last;
        int   guard;
        last  = led1;
        guard = 0;
        while (led1 == last && guard < 6000) begin
            @(negedge clk_sys);
            guard++;
        end
        check(guard < 6000, "R5", "tick seen within window", guard, 6000);
    endtask

    // Monitor: measures one rise-to-rise PWM cycle per expected item.
    initial begin
        forever begin
            int   h, l;
            logic prev;
            exp_t e;
            wait (sb_q.size() > 0);
            @(negedge clk_sys);
            prev = buzzer;
            forever begin
                @(negedge clk_sys);
                if (buzzer && !prev) break;
                prev = buzzer;
            end
            h = 0;
            while (buzzer) begin h++; @(negedge clk_sys); end
            l = 0;
            while (!buzzer) begin l++; @(negedge clk_sys); end
            e = sb_q.pop_front();
            check(h == e.high, e.tag, "high clocks", h, e.high);
            check(h + l == e.total, (e.tag == "R8") ? "R8" : "R1", "cycle clocks",
                  h + l, e.total);
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk_sys);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Driver.
    initial begin
        int   per, thr, step, cur;
        logic exp_led;

        idle(10);
        check(led1 == 1'b1, "R4", "led1 in reset", int'(led1), 1);
        check(led2 == 1'b0, "R4", "led2 in reset", int'(led2), 0);
        check(buzzer == 1'b0, "R2", "buzzer in reset", int'(buzzer), 0);
        idle(30);
        rst_n = 1'b1;

        exp_led = 1'b1;
        per = per_of(0);
        thr = per / 2;
        idle(SETTLE);
        push_exp(per - thr, per + 1, "R4");
        drain();

        for (int t = 1; t <= 10; t++) begin
            wait_tick();
            exp_led = ~exp_led;
            check(led1 == exp_led, "R5", "led1 after tick", int'(led1), int'(exp_led));
            check(led2 != led1, "R5", "led2 opposite led1", int'(led2), int'(~led1));
            cur  = t % 9;
            per  = per_of(cur);
            step = per >> 4;
            thr  = per / 2;
            idle(SETTLE);
            case (t)
                2: begin
                    for (int i = 0; i < 10; i++) begin
                        press(0, 20);
                        thr = (thr + step > per - step) ? per - step : thr + step;
                    end
                    idle(SETTLE);
                    push_exp(per - thr, per + 1, "R7");
                    drain();
                end
                3: begin
                    for (int i = 0; i < 10; i++) begin
                        press(1, 20);
                        thr = (thr - step < step) ? step : thr - step;
                    end
                    idle(SETTLE);
                    push_exp(per - thr, per + 1, "R7");
                    drain();
                end
                4: begin
                    press(0, 3);
                    idle(SETTLE);
                    push_exp(per - thr, per + 1, "R9");
                    drain();
                    press(0, 20);
                    thr = (thr + step > per - step) ? per - step : thr + step;
                    idle(SETTLE);
                    push_exp(per - thr, per + 1, "R7");
                    drain();
                end
                5: begin
                    push_exp(per - thr, per + 1, "R6");
                    drain();
                end
                6: begin
                    logic p;
                    int   new_thr;
                    p = buzzer;
                    forever begin
                        @(negedge clk_sys);
                        if (p && !buzzer) break;
                        p = buzzer;
                    end
                    new_thr = (thr - step < step) ? step : thr - step;
                    push_exp(per - thr, per - thr + new_thr + 1, "R8");
                    press(1, 20);
                    drain();
                    thr = new_thr;
                    idle(SETTLE);
                    push_exp(per - thr, per + 1, "R7");
                    drain();
                end
                9: begin
                    push_exp(per - thr, per + 1, "R6");
                    drain();
                end
                default: begin
                    push_exp(per - thr, per + 1, "R3");
                    drain();
                end
            endcase
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule